// File: doc/BRIEF.md
# Serial converter register interface

This block is the host-facing digital side of a slow delta-sigma converter. A host reaches three registers through a four-wire serial port:

- an 8-bit status register,
- an 8-bit mode register,
- a 24-bit conversion result register.

Every access opens with a command byte. The command byte names the register for the next transfer and says whether that transfer reads or writes. The block keeps a ready flag and an error flag that track conversion results, power-down and result reads. It also reports the input channel selected in the mode register. The modulator and decimation filter are not part of this block. A result stream stands in for them: valid/ready handshake, a 24-bit word and a clamp marker.

The serial port follows SPI mode 3. The clock idles high, the block samples `spi_mosi` on rising clock edges, and it moves `spi_miso` to the next bit after each rising edge, so the host samples `spi_miso` on rising edges too. The port pins are oversampled in the system clock through synchronisers, so the serial clock must stay well below the system clock. While chip select is low and no read data is being shifted out, `spi_miso` carries the ready flag, so a low level tells the host that an unread result is waiting. When chip select is high, `spi_miso_oe` is low and the pad is released.

On the result stream a word is taken on every cycle with `res_valid` and `res_ready` both high. The source must hold the word, its clamp marker and `res_valid` steady until that cycle. The block holds `res_ready` low in two cases: in power-down, and during the whole data phase of a result-register read. This keeps a read from colliding with an update. `res_soon` is a plain warning pin that a result is about to land.

Top module: `cvt_regif`

## Requirements
- R1: A command byte is 8 bits, sent MSB first. Bit 6 is 1 for a read and 0 for a write, bits 5:4 select the register (00 control/status, 01 mode, 10 reserved, 11 result), and bit 7 and bits 3:0 are ignored. After the selected register's full bit count has moved (24 for code 11, 8 for every other code), the port again expects a command byte, with no need to raise chip select.
- R2: A read with code 00 returns the status byte: bit 7 ready flag, bit 6 error flag, bits 5:4 always 0, bit 3 always 1, bit 2 equal to 1 for the 24-bit result width, bits 1:0 the selected channel. After reset it reads 0x8C.
- R3: A read with code 11 returns the stored 24-bit result, MSB first.
- R4: Accepting a result stores it, clears the ready flag and, in the same cycle, sets the error flag to the clamp marker.
- R5: When all 24 bits of a result-register read have been transferred, the ready flag is set.
- R6: A high level on `res_soon` sets the ready flag, unless a result is accepted in that same cycle.
- R7: Mode bit 7 = 1 means power-down. Entering power-down sets the ready flag and drives `pwdn` high, and `res_ready` stays low for as long as power-down lasts.
- R8: Mode bits 1:0 select the channel and drive `chan` and status bits 1:0. A mode write with bit 7 = 0 starts a conversion and clears the error flag.
- R9: Writes with code 00, 10 or 11 take their full bit count and change no register. A read with code 10 returns 0x00.
- R10: With chip select high, `spi_miso_oe` is 0. With chip select low, `spi_miso_oe` is 1 and `spi_miso` equals the ready flag, except while read data is being shifted out.
- R11: `res_ready` is low for the whole data phase of a result-register read, and a word offered meanwhile is held off until the phase ends.
- R12: A read with code 01 returns the last byte written to the mode register, which is 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, or the ready flag when idle |
| spi_miso_oe | output | 1 | Output enable for the `spi_miso` pad |
| res_valid | input | 1 | Result word offered |
| res_ready | output | 1 | Result word can be accepted |
| res_data | input | 24 | Conversion result |
| res_clamp | input | 1 | Result was clamped to all zeros or all ones |
| res_soon | input | 1 | A result is about to arrive |
| chan | output | 2 | Selected input channel |
| pwdn | output | 1 | Power-down requested |

## Verification
A wrong ready flag shows on `spi_miso` as soon as chip select falls and before any clock edge, so the bench probes the idle line as well as the status byte after every result, read and mode change. A framing fault in the command decoder shifts every later transfer by one or more bits, and the very next status or mode read returns a wrong byte. Back-to-back results and a clamped result followed by an unclamped one expose error-flag update mistakes on the next status read. A missing back-pressure term shows at once as a high `res_ready` during power-down or in the middle of a result read.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  // register select codes carried in the command byte
  localparam logic [1:0] RS_CTL  = 2'b00;
  localparam logic [1:0] RS_MODE = 2'b01;
  localparam logic [1:0] RS_RSV  = 2'b10;
  localparam logic [1:0] RS_DATA = 2'b11;

  localparam int CMD_RW_BIT  = 6;
  localparam int CMD_RS_LO   = 4;
  localparam int MODE_PD_BIT = 7;
  localparam int BYTE_W      = 8;

  typedef enum logic {PH_CMD, PH_XFER} phase_e;

  function automatic logic [7:0] status_byte(input logic rdy, input logic err,
                                             input logic wl, input logic [1:0] ch);
    return {rdy, err, 2'b00, 1'b1, wl, ch};
  endfunction
endpackage

// File: rtl/cvt_sync.sv
module cvt_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cvt_spi_front.sv
module cvt_spi_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic bit_stb,
  output logic cs_act,
  output logic din_s
);
  logic [2:0] raw, synced;
  logic       sclk_prev;

  assign raw = {sclk, cs_n, din};

  cvt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_prev <= 1'b1;
    else        sclk_prev <= synced[2];

  // a rising serial clock edge is taken only while selected
  assign bit_stb = synced[2] & ~sclk_prev & ~synced[1];
  assign cs_act  = ~synced[1];
  assign din_s   = synced[0];
endmodule

// File: rtl/cvt_xfer_ctrl.sv
module cvt_xfer_ctrl
  import cvt_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              cs_act,
  input  logic              din,
  input  logic [7:0]        status_b,
  input  logic [7:0]        mode_b,
  input  logic [DATA_W-1:0] data_b,
  output logic              mode_we,
  output logic [7:0]        mode_wd,
  output logic              rd_active,
  output logic              rd_done,
  output logic              tx_en,
  output logic              tx_bit
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam int PAD = DATA_W - BYTE_W;

  phase_e            phase;
  logic [CW-1:0]     cnt, len;
  logic [7:0]        rx;
  logic [7:0]        rx_nx;
  logic [DATA_W-1:0] tx, load_val;
  logic              is_read;
  logic [1:0]        sel;
  logic              cmd_last, xfer_last;
  logic              nx_read;
  logic [1:0]        nx_sel;

  assign rx_nx     = {rx[6:0], din};
  assign nx_read   = rx_nx[CMD_RW_BIT];
  assign nx_sel    = rx_nx[CMD_RS_LO +: 2];
  assign cmd_last  = (cnt == CW'(BYTE_W - 1));
  assign xfer_last = (cnt == len - CW'(1));

  always_comb begin
    load_val = '0;
    if (nx_read) begin
      case (nx_sel)
        RS_CTL:  load_val = {status_b, {PAD{1'b0}}};
        RS_MODE: load_val = {mode_b, {PAD{1'b0}}};
        RS_RSV:  load_val = '0;
        default: load_val = data_b;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_CMD;
      cnt     <= '0;
      len     <= CW'(BYTE_W);
      rx      <= '0;
      tx      <= '0;
      is_read <= 1'b0;
      sel     <= RS_CTL;
    end else if (!cs_act) begin
      phase <= PH_CMD;
      cnt   <= '0;
    end else if (bit_stb) begin
      rx <= rx_nx;
      if (phase == PH_CMD) begin
        if (cmd_last) begin
          cnt     <= '0;
          phase   <= PH_XFER;
          is_read <= nx_read;
          sel     <= nx_sel;
          len     <= (nx_sel == RS_DATA) ? CW'(DATA_W) : CW'(BYTE_W);
          tx      <= load_val;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end else begin
        tx <= {tx[DATA_W-2:0], 1'b0};
        if (xfer_last) begin
          cnt   <= '0;
          phase <= PH_CMD;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  logic xfer_end;
  assign xfer_end  = bit_stb && cs_act && (phase == PH_XFER) && xfer_last;
  assign mode_we   = xfer_end && !is_read && (sel == RS_MODE);
  assign mode_wd   = rx_nx;
  assign rd_done   = xfer_end && is_read && (sel == RS_DATA);
  assign rd_active = (phase == PH_XFER) && is_read && (sel == RS_DATA);
  assign tx_en     = (phase == PH_XFER) && is_read;
  assign tx_bit    = tx[DATA_W-1];
endmodule

// File: rtl/cvt_flags.sv
module cvt_flags #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_clamp,
  input  logic              soon,
  input  logic              pd_set,
  input  logic              conv_start,
  input  logic              rd_done,
  output logic              rdy,
  output logic              err,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy    <= 1'b1;
      err    <= 1'b0;
      data_q <= '0;
    end else begin
      if (acc) data_q <= res_data;
      // set by power-down or completed read beats a fresh result; the result beats the warning
      if (pd_set || rd_done) rdy <= 1'b1;
      else if (acc)          rdy <= 1'b0;
      else if (soon)         rdy <= 1'b1;
      if (acc)             err <= res_clamp;
      else if (conv_start) err <= 1'b0;
    end
  end
endmodule

// File: rtl/cvt_regif.sv
module cvt_regif
  import cvt_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_clamp,
  input  logic              res_soon,
  output logic [1:0]        chan,
  output logic              pwdn
);
  localparam logic WL_ID = (DATA_W == 24);

  logic              bit_stb, cs_act, din_s;
  logic              mode_we, rd_active, rd_done, tx_en, tx_bit;
  logic [7:0]        mode_wd, mode_q, status_b;
  logic              rdy, err, acc, pd_set, conv_start;
  logic [DATA_W-1:0] data_q;

  cvt_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .din(spi_mosi),
    .bit_stb(bit_stb), .cs_act(cs_act), .din_s(din_s)
  );

  cvt_xfer_ctrl #(.DATA_W(DATA_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .cs_act(cs_act), .din(din_s),
    .status_b(status_b), .mode_b(mode_q), .data_b(data_q),
    .mode_we(mode_we), .mode_wd(mode_wd), .rd_active(rd_active), .rd_done(rd_done),
    .tx_en(tx_en), .tx_bit(tx_bit)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= mode_wd;

  assign pwdn       = mode_q[MODE_PD_BIT];
  assign chan       = mode_q[1:0];
  assign res_ready  = !pwdn && !rd_active;
  assign acc        = res_valid && res_ready;
  assign pd_set     = mode_we && mode_wd[MODE_PD_BIT] && !mode_q[MODE_PD_BIT];
  assign conv_start = mode_we && !mode_wd[MODE_PD_BIT];

  cvt_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .acc(acc), .res_data(res_data), .res_clamp(res_clamp),
    .soon(res_soon), .pd_set(pd_set), .conv_start(conv_start), .rd_done(rd_done),
    .rdy(rdy), .err(err), .data_q(data_q)
  );

  assign status_b    = status_byte(rdy, err, WL_ID, mode_q[1:0]);
  assign spi_miso    = tx_en ? tx_bit : rdy;
  assign spi_miso_oe = cs_act;
endmodule

// File: rtl/cvt_regif_chk.sv
module cvt_regif_chk (
  input logic clk,
  input logic rst_n,
  input logic acc,
  input logic res_clamp,
  input logic pd_set,
  input logic rd_done,
  input logic res_soon,
  input logic rd_active,
  input logic res_ready,
  input logic pwdn,
  input logic conv_start,
  input logic rdy,
  input logic err
);
  assert_rdy_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !pd_set) |=> !rdy);

  assert_err_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(acc && res_clamp));

  // R5 and R6: the ready flag rises only after a completed read, a warning or power-down
  assert_rdy_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(rd_done || res_soon || pd_set));

  assert_pd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwdn |-> !res_ready);

  assert_pd_rdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pd_set |=> rdy);

  assert_err_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !acc) |=> !err);

  assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> !res_ready);
endmodule

bind cvt_regif cvt_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc(acc), .res_clamp(res_clamp), .pd_set(pd_set),
  .rd_done(rd_done), .res_soon(res_soon), .rd_active(rd_active), .res_ready(res_ready),
  .pwdn(pwdn), .conv_start(conv_start), .rdy(rdy), .err(err)
);

// File: tb/cvt_regif_bench.sv
`timescale 1ns/1ps
module cvt_regif_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic        miso, miso_oe;
  logic        res_valid = 1'b0, res_clamp = 1'b0, res_soon = 1'b0;
  logic        res_ready;
  logic [23:0] res_data = '0;
  logic [1:0]  chan;
  logic        pwdn;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cvt_regif u_cvt_regif (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_clamp(res_clamp), .res_soon(res_soon),
    .chan(chan), .pwdn(pwdn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_st(input logic r, input logic e, input logic [1:0] c);
    return {r, e, 3'b001, 1'b1, c};
  endfunction

  task automatic spi_bits(input int n, input logic [31:0] w, output logic [31:0] r);
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      sclk = 1'b0;
      mosi = w[i];
      repeat (8) @(negedge clk);
      r[i] = miso;
      sclk = 1'b1;
      repeat (7) @(negedge clk);
    end
  endtask

  task automatic cs_on();
    @(negedge clk); cs_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // command byte: bit 6 read, bits 5:4 register select, other bits free
  task automatic xact(input bit rd, input logic [1:0] rs, input int n,
                      input logic [31:0] w, input logic [7:0] junk, output logic [31:0] r);
    logic [31:0] dummy;
    spi_bits(8, {24'b0, (junk & 8'h8F) | {1'b0, rd, rs, 4'b0}}, dummy);
    spi_bits(n, w, r);
  endtask

  task automatic rd_reg(input logic [1:0] rs, input int n, output logic [31:0] r);
    cs_on(); xact(1'b1, rs, n, 32'h0, 8'h00, r); cs_off();
  endtask

  task automatic wr_reg(input logic [1:0] rs, input int n, input logic [31:0] w);
    logic [31:0] r;
    cs_on(); xact(1'b0, rs, n, w, 8'h00, r); cs_off();
  endtask

  task automatic push(input logic [23:0] d, input logic c);
    @(negedge clk);
    res_valid = 1'b1; res_data = d; res_clamp = c;
    while (!res_ready) @(negedge clk);
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  function automatic logic [23:0] pat(input int k);
    return 24'(k * 24'h1F3A5 + 24'h5A5A5A) ^ 24'(k << 20);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r, r2;
    logic [23:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk("R10 oe with cs high", {31'b0, miso_oe}, 32'd0);
    rd_reg(2'b00, 8, r); chk("R2 status after reset", r, 32'h8C);
    rd_reg(2'b01, 8, r); chk("R12 mode after reset", r, 32'h00);
    chk("R8 chan after reset", {30'b0, chan}, 32'd0);

    // idle line carries the ready flag
    cs_on();
    chk("R10 oe with cs low", {31'b0, miso_oe}, 32'd1);
    chk("R10 idle mirror ready", {31'b0, miso}, 32'd1);
    cs_off();

    // channel sweep
    for (int c = 0; c < 4; c++) begin
      wr_reg(2'b01, 8, 32'(c));
      chk("R8 chan port", {30'b0, chan}, 32'(c));
      rd_reg(2'b00, 8, r); chk("R8 status channel", r, 32'(exp_st(1'b1, 1'b0, 2'(c))));
      rd_reg(2'b01, 8, r); chk("R12 mode readback", r, 32'(c));
    end
    wr_reg(2'b01, 8, 32'h02);

    // result patterns
    for (int k = 0; k < 6; k++) begin
      d = pat(k);
      push(d, k[0]);
      rd_reg(2'b00, 8, r); chk("R4 status after result", r, 32'(exp_st(1'b0, k[0], 2'd2)));
      cs_on(); chk("R10 idle mirror unread", {31'b0, miso}, 32'd0); cs_off();
      rd_reg(2'b11, 24, r); chk("R3 result read", r, {8'b0, d});
      rd_reg(2'b00, 8, r); chk("R5 status after read", r, 32'(exp_st(1'b1, k[0], 2'd2)));
    end

    // back-to-back results, second one wins and rewrites the error flag
    push(24'hFFFFFF, 1'b1);
    push(24'h123456, 1'b0);
    rd_reg(2'b00, 8, r); chk("R4 back-to-back status", r, 32'(exp_st(1'b0, 1'b0, 2'd2)));

    // warning pin raises ready
    @(negedge clk); res_soon = 1'b1;
    @(negedge clk); res_soon = 1'b0;
    rd_reg(2'b00, 8, r); chk("R6 warning sets ready", r, 32'(exp_st(1'b1, 1'b0, 2'd2)));
    rd_reg(2'b11, 24, r); chk("R3 result kept after warning", r, 32'h123456);

    // conversion start clears the error flag
    push(24'h000000, 1'b1);
    rd_reg(2'b00, 8, r); chk("R4 clamp sets error", r, 32'(exp_st(1'b0, 1'b1, 2'd2)));
    wr_reg(2'b01, 8, 32'h02);
    rd_reg(2'b00, 8, r); chk("R8 start clears error", r, 32'(exp_st(1'b0, 1'b0, 2'd2)));

    // ignored writes
    wr_reg(2'b10, 8, 32'hFF);
    wr_reg(2'b00, 8, 32'hFF);
    wr_reg(2'b11, 24, 32'hFFFFFF);
    rd_reg(2'b01, 8, r); chk("R9 mode untouched", r, 32'h02);
    rd_reg(2'b00, 8, r); chk("R9 status untouched", r, 32'(exp_st(1'b0, 1'b0, 2'd2)));
    rd_reg(2'b11, 24, r); chk("R9 result untouched", r, 32'h000000);
    rd_reg(2'b10, 8, r); chk("R9 reserved reads zero", r, 32'h00);

    // framing: free command bits, several transfers inside one selection
    cs_on();
    xact(1'b1, 2'b00, 8, 32'h0, 8'h8F, r);
    xact(1'b1, 2'b01, 8, 32'h0, 8'h8A, r2);
    cs_off();
    chk("R1 free bits ignored", r, 32'(exp_st(1'b1, 1'b0, 2'd2)));
    chk("R1 second command in same select", r2, 32'h02);

    // power-down with a result waiting at the port
    wr_reg(2'b01, 8, 32'h82);
    chk("R7 pwdn port", {31'b0, pwdn}, 32'd1);
    rd_reg(2'b00, 8, r); chk("R7 power-down sets ready", r, 32'(exp_st(1'b1, 1'b0, 2'd2)));
    @(negedge clk); res_valid = 1'b1; res_data = 24'hABCDEF; res_clamp = 1'b0;
    repeat (100) @(negedge clk);
    chk("R7 ready held low", {31'b0, res_ready}, 32'd0);
    rd_reg(2'b11, 24, r); chk("R7 result not taken", r, 32'h000000);
    wr_reg(2'b01, 8, 32'h02);
    res_valid = 1'b0;
    chk("R7 woken", {31'b0, pwdn}, 32'd0);
    rd_reg(2'b11, 24, r); chk("R7 result after wake", r, 32'hABCDEF);

    // back-pressure during a result read
    push(24'h5C3A91, 1'b0);
    cs_on();
    spi_bits(8, 32'h70, r2);
    spi_bits(12, 32'h0, r);
    chk("R11 ready low mid read", {31'b0, res_ready}, 32'd0);
    spi_bits(12, 32'h0, r2);
    cs_off();
    chk("R11 split read value", {8'b0, r[11:0], r2[11:0]}, 32'h5C3A91);
    chk("R11 ready after read", {31'b0, res_ready}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule